// File: doc/BRIEF.md
# Thread Interrupt Context Presenter

This block keeps the interrupt presentation context for a small cluster of hardware threads. Each thread has a notification status byte, a current processor priority (CPPR, 0 is most urgent and 0xFF masks nothing), a pending-priority bitmap for directed interrupts, and a lowest-backlog priority byte. Interrupt requests come in on a valid/ready stream. A request carries a target index, a group flag and a 3-bit priority. A directed request names one thread. A group request names a power-of-two set of threads and is delivered to one member that can take it.

When no member of a group can take a group request, the request goes into a small backlog table. It stays there until some member becomes eligible, usually because software raised that member's CPPR. It is then presented on that member without any further request. Software sees a thread's context as one 32-bit word through a read port, can write the CPPR, and takes an interrupt with an acknowledge read. The acknowledge read returns the status and the interrupt's priority, then moves the thread's CPPR to that priority.

The request stream follows the usual valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The source must hold the request stable while `req_ready` is low. `req_ready` does not depend on `req_valid`.

Top module: `tic_presenter`

## Requirements
- R1: After reset every thread's context word reads {status 0x00, CPPR 0xFF, bitmap 0x00, lowest backlog 0xFF}. The word layout is status in [31:24], CPPR in [23:16], bitmap in [15:8] and lowest backlog in [7:0].
- R2: A directed request of priority p to thread t (target index equal to t, group flag 0) sets bitmap bit 0x80 >> p of that thread. A directed target index with no matching thread has no effect.
- R3: A thread with status 0 presents its most urgent pending bitmap priority q with status 0x40 only when q is numerically below its CPPR. A more urgent directed priority that arrives while 0x40 is shown replaces the presented priority. With CPPR at 0 nothing is presented.
- R4: A group request is delivered with status 0x82 to the lowest-numbered member that is eligible. A member is eligible when its status is 0, p is below its CPPR, and it has no pending bitmap bit at priority p or more urgent. Delivery is seen on the edge that accepts the request.
- R5: The number k of trailing ones in a group target gives a group of 2^(k+1) threads. The members are the threads whose index matches the target above bit k. One trailing one gives 4 threads, three give 16, and none gives 2. A group that contains no existing thread is accepted and dropped.
- R6: A group request with no eligible member is stored in the backlog. It leaves every status at 0, and each member's lowest-backlog byte shows the most urgent backlogged priority that includes that member.
- R7: When a member of a backlogged group becomes eligible, for example after a CPPR write above the backlogged priority, that member shows status 0x82 one edge after the write edge. The entry is removed, and lowest-backlog bytes return to 0xFF once no entry covers the thread. The most urgent entry is served first.
- R8: An acknowledge read returns {status, priority} when status is non-zero. It then sets CPPR to that priority, clears the status, and for status 0x40 clears that bitmap bit. With status 0 it returns {0x00, CPPR} and changes nothing.
- R9: `req_ready` is low in any cycle that has a CPPR write, an acknowledge, or a backlog delivery, and whenever the backlog table is full. A stalled request is taken unchanged once `req_ready` returns high.
- R10: Writing CPPR to 0xFF on a thread with nothing pending leaves its status at 0 and its word at the reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_target | input | TGT_W | Thread index (directed) or group code (group) |
| req_group | input | 1 | 1 for a group request |
| req_prio | input | 3 | Request priority, 0 most urgent |
| cppr_wr_en | input | 1 | CPPR write strobe |
| cppr_wr_thread | input | THR_W | Thread written |
| cppr_wr_data | input | 8 | New CPPR value |
| ctx_rd_thread | input | THR_W | Thread whose context word is shown |
| ctx_rd_word | output | 32 | {status, CPPR, bitmap, lowest backlog} |
| ack_en | input | 1 | Acknowledge read strobe |
| ack_thread | input | THR_W | Thread acknowledged |
| ack_word | output | 16 | {status, priority or CPPR}, valid before the edge |

## Verification
Two functions can fall in the same cycle. A request can arrive together with a CPPR write or an acknowledge. A pending backlog delivery can also compete with a fresh group request for the same eligible thread. The bench provokes the first case by driving `req_valid` in the same cycle as `cppr_wr_en`. It expects `req_ready` low there, and expects the request to be taken one cycle later and delivered to the right thread. It provokes the second case by filling the backlog table and then unmasking threads. It expects the stall while the table is full, one backlog delivery per cycle, and in the end every context word back at its reset value.

// File: rtl/tic_pkg.sv
package tic_pkg;

  localparam int PRIO_W = 3;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [7:0]        byte_t;

  localparam byte_t NSR_IDLE   = 8'h00;
  localparam byte_t NSR_DIRECT = 8'h40;
  localparam byte_t NSR_GROUP  = 8'h82;

  // one-hot bitmap position of a priority, most urgent in the top bit
  function automatic byte_t prio_bit(prio_t p);
    return 8'h80 >> p;
  endfunction

  // bitmap bits of priority p and every more urgent priority
  function automatic byte_t urgent_mask(prio_t p);
    logic [3:0] sh;
    sh = {1'b0, p} + 4'd1;
    return ~(8'hFF >> sh);
  endfunction

  // a thread may take a group interrupt of priority p
  function automatic logic can_take(byte_t nsr, byte_t cppr, byte_t ipb, prio_t p);
    return (nsr == NSR_IDLE) && ({5'b0, p} < cppr) &&
           ((ipb & urgent_mask(p)) == 8'h00);
  endfunction

endpackage

// File: rtl/tic_target_decode.sv
module tic_target_decode
  import tic_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TGT_W       = 6
) (
  input  logic [TGT_W-1:0]       target,
  input  logic                   group,
  output logic [NUM_THREADS-1:0] members
);

  int  ones;
  int  span;
  logic run;

  // trailing ones count sets the group span
  always_comb begin
    ones = 0;
    run  = 1'b1;
    for (int b = 0; b < TGT_W; b++) begin
      if (run && target[b]) ones = ones + 1;
      else                  run  = 1'b0;
    end
    span = (ones + 1 > TGT_W) ? TGT_W : ones + 1;
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_mem
    localparam logic [TGT_W-1:0] TIDX = TGT_W'(t);
    logic hi_match;
    always_comb begin
      hi_match = 1'b1;
      for (int b = 0; b < TGT_W; b++)
        if (b >= span && TIDX[b] != target[b]) hi_match = 1'b0;
    end
    assign members[t] = group ? hi_match : (target == TIDX);
  end

endmodule

// File: rtl/tic_thread_ctx.sv
module tic_thread_ctx
  import tic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dir_set,
  input  prio_t dir_prio,
  input  logic  grp_set,
  input  prio_t grp_prio,
  input  logic  ack,
  input  logic  cppr_wr,
  input  byte_t cppr_data,
  output byte_t nsr,
  output byte_t cppr,
  output byte_t ipb,
  output prio_t pipr
);

  byte_t nsr_n, cppr_n, ipb_n;
  prio_t pipr_n;
  prio_t best;
  logic  has_best;

  // most urgent pending directed priority
  always_comb begin
    best     = '0;
    has_best = 1'b0;
    for (int q = 7; q >= 0; q--) begin
      if (ipb[7-q]) begin
        best     = prio_t'(q);
        has_best = 1'b1;
      end
    end
  end

  always_comb begin
    nsr_n  = nsr;
    cppr_n = cppr;
    ipb_n  = ipb;
    pipr_n = pipr;
    if (ack && nsr != NSR_IDLE) begin
      cppr_n = {5'b0, pipr};
      if (nsr == NSR_DIRECT) ipb_n = ipb & ~prio_bit(pipr);
      nsr_n = NSR_IDLE;
    end else if (grp_set) begin
      nsr_n  = NSR_GROUP;
      pipr_n = grp_prio;
    end else if (nsr == NSR_IDLE && has_best && {5'b0, best} < cppr) begin
      nsr_n  = NSR_DIRECT;
      pipr_n = best;
    end else if (nsr == NSR_DIRECT && has_best && best < pipr) begin
      pipr_n = best;
    end
    if (dir_set) ipb_n = ipb_n | prio_bit(dir_prio);
    if (cppr_wr) cppr_n = cppr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nsr  <= NSR_IDLE;
      cppr <= 8'hFF;
      ipb  <= 8'h00;
      pipr <= '0;
    end else begin
      nsr  <= nsr_n;
      cppr <= cppr_n;
      ipb  <= ipb_n;
      pipr <= pipr_n;
    end
  end

endmodule

// File: rtl/tic_backlog.sv
module tic_backlog
  import tic_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int DEPTH       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hold,
  input  logic                         st_en,
  input  prio_t                        st_prio,
  input  logic [NUM_THREADS-1:0]       st_mask,
  input  logic [NUM_THREADS-1:0][7:0]  thr_nsr,
  input  logic [NUM_THREADS-1:0][7:0]  thr_cppr,
  input  logic [NUM_THREADS-1:0][7:0]  thr_ipb,
  output logic                         full,
  output logic                         gnt_valid,
  output prio_t                        gnt_prio,
  output logic [NUM_THREADS-1:0]       gnt_onehot,
  output logic [NUM_THREADS-1:0][7:0]  lsmfb
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]       valid_q;
  prio_t                  prio_q [DEPTH];
  logic [NUM_THREADS-1:0] mask_q [DEPTH];
  logic [NUM_THREADS-1:0] elig   [DEPTH];

  logic             found;
  logic [IDX_W-1:0] sel;
  logic             free_ok;
  logic [IDX_W-1:0] free_idx;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      assign elig[e][t] = valid_q[e] && mask_q[e][t] &&
                          can_take(thr_nsr[t], thr_cppr[t], thr_ipb[t], prio_q[e]);
    end
  end

  // most urgent serviceable entry, lowest slot on a tie
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (|elig[e] && (!found || prio_q[e] < prio_q[sel])) begin
        found = 1'b1;
        sel   = IDX_W'(e);
      end
    end
  end

  always_comb begin
    gnt_onehot = '0;
    if (found && !hold) begin
      for (int t = NUM_THREADS - 1; t >= 0; t--)
        if (elig[sel][t]) gnt_onehot = NUM_THREADS'(1) << t;
    end
  end

  assign gnt_valid = found && !hold;
  assign gnt_prio  = prio_q[sel];

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (!valid_q[e]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(e);
      end
    end
  end

  assign full = !free_ok;

  // lowest backlogged priority covering each thread
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_low
    always_comb begin
      lsmfb[t] = 8'hFF;
      for (int e = 0; e < DEPTH; e++)
        if (valid_q[e] && mask_q[e][t] && {5'b0, prio_q[e]} < lsmfb[t])
          lsmfb[t] = {5'b0, prio_q[e]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        prio_q[e] <= '0;
        mask_q[e] <= '0;
      end
    end else begin
      if (gnt_valid) valid_q[sel] <= 1'b0;
      if (st_en && free_ok) begin
        valid_q[free_idx] <= 1'b1;
        prio_q[free_idx]  <= st_prio;
        mask_q[free_idx]  <= st_mask;
      end
    end
  end

endmodule

// File: rtl/tic_presenter.sv
module tic_presenter
  import tic_pkg::*;
#(
  parameter  int NUM_THREADS = 4,
  parameter  int TGT_W       = 6,
  parameter  int BL_DEPTH    = 4,
  localparam int THR_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TGT_W-1:0] req_target,
  input  logic             req_group,
  input  logic [2:0]       req_prio,
  input  logic             cppr_wr_en,
  input  logic [THR_W-1:0] cppr_wr_thread,
  input  logic [7:0]       cppr_wr_data,
  input  logic [THR_W-1:0] ctx_rd_thread,
  output logic [31:0]      ctx_rd_word,
  input  logic             ack_en,
  input  logic [THR_W-1:0] ack_thread,
  output logic [15:0]      ack_word
);

  logic [NUM_THREADS-1:0][7:0] thr_nsr, thr_cppr, thr_ipb, thr_lsmfb;
  prio_t                       thr_pipr [NUM_THREADS];

  logic [NUM_THREADS-1:0] members, grp_elig, grp_pick;
  logic [NUM_THREADS-1:0] bl_onehot;
  logic                   bl_full, bl_gnt;
  prio_t                  bl_prio;
  logic                   sw_busy, req_fire, grp_fire, bl_store;

  assign sw_busy   = cppr_wr_en || ack_en;
  assign req_ready = !sw_busy && !bl_gnt && !bl_full;
  assign req_fire  = req_valid && req_ready;
  assign grp_fire  = req_fire && req_group;

  tic_target_decode #(
    .NUM_THREADS(NUM_THREADS),
    .TGT_W      (TGT_W)
  ) dec_i (
    .target (req_target),
    .group  (req_group),
    .members(members)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_elig
    assign grp_elig[t] = members[t] &&
                         can_take(thr_nsr[t], thr_cppr[t], thr_ipb[t], req_prio);
  end

  // lowest-numbered eligible member
  always_comb begin
    grp_pick = '0;
    for (int t = NUM_THREADS - 1; t >= 0; t--)
      if (grp_elig[t]) grp_pick = NUM_THREADS'(1) << t;
  end

  assign bl_store = grp_fire && (|members) && !(|grp_elig);

  tic_backlog #(
    .NUM_THREADS(NUM_THREADS),
    .DEPTH      (BL_DEPTH)
  ) bl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (sw_busy),
    .st_en     (bl_store),
    .st_prio   (req_prio),
    .st_mask   (members),
    .thr_nsr   (thr_nsr),
    .thr_cppr  (thr_cppr),
    .thr_ipb   (thr_ipb),
    .full      (bl_full),
    .gnt_valid (bl_gnt),
    .gnt_prio  (bl_prio),
    .gnt_onehot(bl_onehot),
    .lsmfb     (thr_lsmfb)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic sel_wr, sel_ack, dset, gset;
    assign sel_wr  = cppr_wr_en && (cppr_wr_thread == THR_W'(t));
    assign sel_ack = ack_en && (ack_thread == THR_W'(t));
    assign dset    = req_fire && !req_group && members[t];
    assign gset    = (grp_fire && grp_pick[t]) || bl_onehot[t];

    tic_thread_ctx ctx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_set  (dset),
      .dir_prio (req_prio),
      .grp_set  (gset),
      .grp_prio (bl_gnt ? bl_prio : req_prio),
      .ack      (sel_ack),
      .cppr_wr  (sel_wr),
      .cppr_data(cppr_wr_data),
      .nsr      (thr_nsr[t]),
      .cppr     (thr_cppr[t]),
      .ipb      (thr_ipb[t]),
      .pipr     (thr_pipr[t])
    );
  end

  always_comb begin
    ctx_rd_word = '0;
    ack_word    = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (ctx_rd_thread == THR_W'(t))
        ctx_rd_word = {thr_nsr[t], thr_cppr[t], thr_ipb[t], thr_lsmfb[t]};
      if (ack_thread == THR_W'(t))
        ack_word = {thr_nsr[t],
                    (thr_nsr[t] != NSR_IDLE) ? {5'b0, thr_pipr[t]} : thr_cppr[t]};
    end
  end

endmodule

// File: rtl/tic_presenter_chk.sv
module tic_presenter_chk #(
  parameter int NUM_THREADS = 4,
  parameter int THR_W       = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_ready,
  input logic                        cppr_wr_en,
  input logic                        ack_en,
  input logic [THR_W-1:0]            ack_thread,
  input logic                        bl_full,
  input logic [NUM_THREADS-1:0][7:0] thr_nsr,
  input logic [NUM_THREADS-1:0][7:0] thr_cppr,
  input logic [NUM_THREADS-1:0][7:0] thr_lsmfb
);

  AST_STALL_ON_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_wr_en || ack_en) |-> !req_ready); // R9

  AST_STALL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    bl_full |-> !req_ready); // R9

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_nsr[t] == 8'h00) || (thr_nsr[t] == 8'h40) || (thr_nsr[t] == 8'h82)); // R4

    AST_CPPR0_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_nsr[t] == 8'h00 && thr_cppr[t] == 8'h00) |=> (thr_nsr[t] == 8'h00)); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && ack_thread == THR_W'(t) && thr_nsr[t] != 8'h00)
        |=> (thr_nsr[t] == 8'h00)); // R8

    AST_BACKLOG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_lsmfb[t] == 8'hFF) || (thr_lsmfb[t] < 8'h08)); // R6
  end

endmodule

bind tic_presenter tic_presenter_chk #(
  .NUM_THREADS(NUM_THREADS),
  .THR_W      (THR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cppr_wr_en(cppr_wr_en),
  .ack_en    (ack_en),
  .ack_thread(ack_thread),
  .bl_full   (bl_full),
  .thr_nsr   (thr_nsr),
  .thr_cppr  (thr_cppr),
  .thr_lsmfb (thr_lsmfb)
);

// File: tb/tic_presenter_tb_top.sv
`timescale 1ns/100ps
module tic_presenter_tb_top;

  localparam int NT = 4;
  localparam int TW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [TW-1:0] req_target = '0;
  logic        req_group = 1'b0;
  logic [2:0]  req_prio = '0;
  logic        cppr_wr_en = 1'b0;
  logic [1:0]  cppr_wr_thread = '0;
  logic [7:0]  cppr_wr_data = '0;
  logic [1:0]  ctx_rd_thread = '0;
  logic [31:0] ctx_rd_word;
  logic        ack_en = 1'b0;
  logic [1:0]  ack_thread = '0;
  logic [15:0] ack_word;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  tic_presenter #(.NUM_THREADS(NT), .TGT_W(TW), .BL_DEPTH(4)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int tgt, bit grp, int p);
    @(negedge clk);
    req_valid = 1'b1; req_target = TW'(tgt); req_group = grp; req_prio = 3'(p);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_cppr(int t, int v);
    @(negedge clk);
    cppr_wr_en = 1'b1; cppr_wr_thread = 2'(t); cppr_wr_data = 8'(v);
    @(negedge clk);
    cppr_wr_en = 1'b0;
  endtask

  task automatic ack(int t, output logic [15:0] w);
    @(negedge clk);
    ack_en = 1'b1; ack_thread = 2'(t);
    #1 w = ack_word;
    @(negedge clk);
    ack_en = 1'b0;
  endtask

  task automatic rd(int t, output logic [31:0] w);
    ctx_rd_thread = 2'(t);
    #1 w = ctx_rd_word;
  endtask

  function automatic logic [31:0] ctx(int n, int c, int i, int l);
    return {8'(n), 8'(c), 8'(i), 8'(l)};
  endfunction

  task automatic all_reset_state(string tag);
    logic [31:0] w;
    for (int t = 0; t < NT; t++) begin
      rd(t, w);
      chk(tag, w, ctx(0, 8'hFF, 0, 8'hFF));
    end
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w;
    logic [15:0] a;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    all_reset_state("R1 reset word");

    // R8: acknowledge with nothing presented
    ack(0, a);
    chk("R8 idle ack", {16'h0, a}, {16'h0, 16'h00FF});
    all_reset_state("R8 idle ack no change");

    // R2/R3/R8/R10 directed sweep over thread and priority
    for (int t = 0; t < NT; t++) begin
      for (int p = 0; p < 8; p++) begin
        send(t, 1'b0, p);
        idle(2);
        rd(t, w);
        chk("R2 R3 directed shown", w, ctx(8'h40, 8'hFF, 8'h80 >> p, 8'hFF));
        ack(t, a);
        chk("R8 directed ack", {16'h0, a}, {16'h0, 8'h40, 8'(p)});
        idle(1);
        rd(t, w);
        chk("R8 after ack", w, ctx(0, p, 0, 8'hFF));
        wr_cppr(t, 8'hFF);
        idle(2);
        rd(t, w);
        chk("R10 cppr ff", w, ctx(0, 8'hFF, 0, 8'hFF));
      end
    end

    // R3 held back when priority is not below CPPR
    for (int p = 0; p < 8; p++) begin
      wr_cppr(1, p);
      send(1, 1'b0, p);
      idle(2);
      rd(1, w);
      chk("R3 held", w, ctx(0, p, 8'h80 >> p, 8'hFF));
      wr_cppr(1, p + 1);
      idle(2);
      rd(1, w);
      chk("R3 released", w, ctx(8'h40, p + 1, 8'h80 >> p, 8'hFF));
      ack(1, a);
      chk("R8 released ack", {16'h0, a}, {16'h0, 8'h40, 8'(p)});
      wr_cppr(1, 8'hFF);
      idle(2);
    end
    all_reset_state("R3 cleanup");

    // R3 preemption by a more urgent directed priority
    send(2, 1'b0, 5);
    idle(2);
    send(2, 1'b0, 2);
    idle(2);
    ack(2, a);
    chk("R3 preempt ack", {16'h0, a}, {16'h0, 16'h4002});
    idle(1);
    rd(2, w);
    chk("R3 residual pending", w, ctx(0, 2, 8'h04, 8'hFF));
    wr_cppr(2, 8'hFF);
    idle(2);
    ack(2, a);
    chk("R3 second ack", {16'h0, a}, {16'h0, 16'h4005});
    wr_cppr(2, 8'hFF);
    idle(2);

    // R2 directed to a missing thread
    send(9, 1'b0, 4);
    idle(3);
    all_reset_state("R2 missing thread");

    // R4 group of 4 over all priorities: lowest free member wins
    for (int p = 0; p < 8; p++) begin
      send(8'h01, 1'b1, p);
      idle(1);
      rd(0, w);
      chk("R4 first member", w, ctx(8'h82, 8'hFF, 0, 8'hFF));
      send(8'h01, 1'b1, p);
      idle(1);
      rd(1, w);
      chk("R4 next member", w, ctx(8'h82, 8'hFF, 0, 8'hFF));
      ack(0, a);
      chk("R8 group ack t0", {16'h0, a}, {16'h0, 8'h82, 8'(p)});
      ack(1, a);
      chk("R8 group ack t1", {16'h0, a}, {16'h0, 8'h82, 8'(p)});
      wr_cppr(0, 8'hFF);
      wr_cppr(1, 8'hFF);
      idle(2);
    end
    all_reset_state("R4 cleanup");

    // R5 group of 16 reaches thread 3 when others are masked
    for (int t = 0; t < 3; t++) wr_cppr(t, 0);
    send(8'h07, 1'b1, 4);
    idle(1);
    rd(3, w);
    chk("R5 group16", w, ctx(8'h82, 8'hFF, 0, 8'hFF));
    ack(3, a);
    chk("R5 group16 ack", {16'h0, a}, {16'h0, 16'h8204});
    for (int t = 0; t < NT; t++) wr_cppr(t, 8'hFF);
    idle(2);

    // R5 group of 2 (no trailing ones) starting at thread 2
    send(8'h02, 1'b1, 6);
    idle(1);
    rd(2, w);
    chk("R5 group2", w, ctx(8'h82, 8'hFF, 0, 8'hFF));
    rd(0, w);
    chk("R5 group2 excludes t0", w, ctx(0, 8'hFF, 0, 8'hFF));
    ack(2, a);
    wr_cppr(2, 8'hFF);
    idle(2);

    // R5 group with no existing member is dropped
    send(8'h05, 1'b1, 1);
    idle(3);
    all_reset_state("R5 empty group");

    // R6/R7 blocked group goes to backlog, released by a CPPR write
    for (int t = 0; t < NT; t++) wr_cppr(t, 2);
    send(8'h01, 1'b1, 3);
    idle(1);
    for (int t = 0; t < NT; t++) begin
      rd(t, w);
      chk("R6 backlog word", w, ctx(0, 2, 0, 3));
    end
    wr_cppr(3, 4);
    idle(1);
    rd(3, w);
    chk("R7 backlog shown", w, ctx(8'h82, 4, 0, 8'hFF));
    rd(0, w);
    chk("R7 backlog gone", w, ctx(0, 2, 0, 8'hFF));
    ack(3, a);
    chk("R8 backlog ack", {16'h0, a}, {16'h0, 16'h8203});
    for (int t = 0; t < NT; t++) wr_cppr(t, 8'hFF);
    idle(2);
    all_reset_state("R7 cleanup");

    // R6/R7 two entries: most urgent served first
    for (int t = 0; t < NT; t++) wr_cppr(t, 0);
    send(8'h01, 1'b1, 6);
    send(8'h01, 1'b1, 1);
    idle(1);
    rd(2, w);
    chk("R6 min backlog", w, ctx(0, 0, 0, 1));
    wr_cppr(0, 8'hFF);
    idle(1);
    ack(0, a);
    chk("R7 urgent first", {16'h0, a}, {16'h0, 16'h8201});
    rd(2, w);
    chk("R7 remaining backlog", w, ctx(0, 0, 0, 6));
    wr_cppr(1, 7);
    idle(1);
    rd(1, w);
    chk("R7 second release", w, ctx(8'h82, 7, 0, 8'hFF));
    ack(1, a);
    chk("R7 second ack", {16'h0, a}, {16'h0, 16'h8206});
    for (int t = 0; t < NT; t++) wr_cppr(t, 8'hFF);
    idle(2);
    all_reset_state("R7 two-entry cleanup");

    // R9 request in the same cycle as a CPPR write is stalled
    @(negedge clk);
    req_valid = 1'b1; req_target = 6'h01; req_group = 1'b1; req_prio = 3'd5;
    cppr_wr_en = 1'b1; cppr_wr_thread = 2'd0; cppr_wr_data = 8'h03;
    #1 chk("R9 stall on write", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    cppr_wr_en = 1'b0;
    #1 chk("R9 ready after write", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    rd(1, w);
    chk("R9 stalled request delivered", w, ctx(8'h82, 8'hFF, 0, 8'hFF));
    ack(1, a);
    wr_cppr(1, 8'hFF);
    wr_cppr(0, 8'hFF);
    idle(2);

    // R9 backlog full stalls the stream
    for (int t = 0; t < NT; t++) wr_cppr(t, 0);
    for (int k = 0; k < 4; k++) send(8'h01, 1'b1, 3);
    @(negedge clk);
    req_valid = 1'b1; req_target = 6'h01; req_group = 1'b1; req_prio = 3'd3;
    #1 chk("R9 stall on full", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int r = 0; r < 6; r++) begin
      for (int t = 0; t < NT; t++) begin
        ack(t, a);
        wr_cppr(t, 8'hFF);
      end
      idle(3);
    end
    all_reset_state("R9 drain");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule